// File: doc/BRIEF.md
# CCD Sensor Drive Timing Generator

This block produces the full digital drive sequence for an interline transfer CCD with a complementary colour mosaic that is read out one field at a time. A master clock with a clock enable paces it. Each enabled tick is one quarter of a pixel period. A pixel counter and a line counter run inside this clock. They are decoded into the following outputs:
- horizontal and vertical sync references, a blanking flag and a field flag;
- the two-phase horizontal register clocks and the per-pixel reset gate;
- the four-phase vertical register clocks;
- the field-dependent readout gate pulses;
- the substrate drain pulses of the electronic shutter;
- clamp and sample strobes for the correlated sampler that follows the sensor.

Every line starts with a horizontal blanking interval. All vertical activity happens inside that interval: the vertical shift, the readout gate and the substrate drain. After blanking comes the transfer region, which holds the front optical black pixels, the effective pixels and the rear optical black pixels, in that order. Fields alternate between a longer first field and a shorter second field, so that two fields make one interlaced frame.

The exposure length is set by a shutter value given in lines. It is latched only at a field boundary. Its effect is to suppress substrate pulses on the last lines of the field. The block has no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain control levels.

Top module: `ccd_timing_gen`

## Requirements
- R1: The tick phase (0..3), the pixel counter and the line counter advance only on cycles with `pix_en` high. With `pix_en` low, every output holds its value.
- R2: In the transfer region (pixel index >= H_BLANK), `h1` is high on tick phases 0 and 1, and `h2` is high on tick phases 2 and 3. `rg` is high only on tick phase 0. In blanking, `h1`=1, `h2`=0 and `rg`=0.
- R3: `hd` is high while the pixel index is below HD_WIDTH. `vd` is high while the line index within the field is below VD_WIDTH.
- R4: The field with `field`=0 lasts LINES_ODD lines, and the field with `field`=1 lasts LINES_EVEN lines. `field` toggles only at the start of a field.
- R5: `ob_clamp` pulses on tick phase 2 on every transfer-region pixel of the V_OB optical black lines that follow V_BLANK. On the active lines, it pulses only on the H_OB_FRONT front and H_OB_REAR rear pixels.
- R6: On active lines (the V_ACT lines after the optical black lines), `samp_strobe` pulses on tick phase 2 of each of the H_EFF effective pixels. `blank` is low exactly on those effective pixels.
- R7: `vclk` (bit 0 = phase 1) rests at 0011. In the window starting at VT_START, it steps through 0110, 1100, 1001 and 0011, holding each pattern for 2**STEP_LG pixels. Exactly two adjacent phases are high at all times, and the pattern changes only while `h2` is low.
- R8: On line RD_LINE, for pixels [RD_START, RD_START+RD_WIDTH), `rdg_a` is high in field 0 and `rdg_b` is high in field 1. The two are never high together, and neither is high anywhere else.
- R9: Let S be the latched shutter value and FL the length of the current field. `sub_pulse` is high for pixels [SUB_START, SUB_START+SUB_WIDTH) on a line `ln` exactly when S != 0, `ln` >= V_BLANK and `ln` + S < FL. S = 0 gives no pulses.
- R10: S takes the value of `shut_lines` on the final tick of each field. A change to `shut_lines` in mid-field has no effect until the next field.
- R11: A synchronous `rst` clears the tick phase and both counters, sets `field` to 0 and sets S to 0. The first cycle after reset therefore shows `hd`=`vd`=`blank`=1 and `vclk`=0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Quarter-pixel tick enable |
| shut_lines | input | SHUT_W | Shutter length in lines before field end; 0 disables the shutter |
| hd | output | 1 | Horizontal sync reference |
| vd | output | 1 | Vertical sync reference |
| blank | output | 1 | High outside effective pixels of active lines |
| field | output | 1 | Field flag (0 = longer field) |
| h1 | output | 1 | Horizontal transfer clock phase 1 |
| h2 | output | 1 | Horizontal transfer clock phase 2 |
| rg | output | 1 | Reset gate pulse |
| vclk | output | 4 | Vertical transfer phases, bit 0 = phase 1 |
| rdg_a | output | 1 | Readout gate for field 0 |
| rdg_b | output | 1 | Readout gate for field 1 |
| sub_pulse | output | 1 | Substrate drain pulse |
| ob_clamp | output | 1 | Optical black clamp strobe |
| samp_strobe | output | 1 | Effective pixel sample strobe |

## Verification
The outputs are decoded combinationally from three counters, so any wrong counter state appears at the ports on the very next cycle.
- A pixel count that is off by one moves the `h1`/`h2` boundary and the strobe positions inside that same line.
- A line count or field length error shifts `vd`, the readout gate line and the substrate line window within one field.
- A shutter value latched at the wrong moment changes the number of `sub_pulse` lines in the field that follows.

The bench therefore compares every output on every cycle against a position computed arithmetically from the total count of enabled ticks. It sweeps many frames of a reduced geometry with irregular enables, varied shutter values and a reset in mid-run.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef logic [3:0] vphase_t;

  // idle pattern: phases 1 and 2 high
  localparam vphase_t VREST = 4'b0011;

  // one step of the four-phase shift, each step moves the charge packet by a quarter
  function automatic vphase_t vstep(input logic [1:0] s);
    case (s)
      2'd0:    return 4'b0110;
      2'd1:    return 4'b1100;
      2'd2:    return 4'b1001;
      default: return 4'b0011;
    endcase
  endfunction
endpackage

// File: rtl/ccd_tg_hcnt.sv
module ccd_tg_hcnt #(
  parameter int H_TOTAL = 637,
  parameter int PW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  output logic [1:0]    tick,
  output logic [PW-1:0] px,
  output logic          line_end
);
  localparam logic [PW-1:0] PX_LAST = PW'(H_TOTAL - 1);

  assign line_end = pix_en && (tick == 2'd3) && (px == PX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= 2'd0;
      px   <= '0;
    end else if (pix_en) begin
      tick <= tick + 2'd1;
      if (tick == 2'd3) px <= (px == PX_LAST) ? '0 : px + PW'(1);
    end
  end
endmodule

// File: rtl/ccd_tg_vcnt.sv
module ccd_tg_vcnt #(
  parameter int LINES_ODD  = 263,
  parameter int LINES_EVEN = 262,
  parameter int LW         = 9,
  parameter int SW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [SW-1:0] shut_in,
  output logic [LW-1:0] ln,
  output logic          field,
  output logic [SW-1:0] shut_q
);
  logic field_last;

  assign field_last = field ? (ln == LW'(LINES_EVEN - 1)) : (ln == LW'(LINES_ODD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ln     <= '0;
      field  <= 1'b0;
      shut_q <= '0;
    end else if (line_end) begin
      if (field_last) begin
        ln     <= '0;
        field  <= ~field;
        shut_q <= shut_in;   // exposure value only changes between fields
      end else begin
        ln <= ln + LW'(1);
      end
    end
  end
endmodule

// File: rtl/ccd_tg_vdrv.sv
module ccd_tg_vdrv
  import ccd_tg_pkg::*;
#(
  parameter int PW         = 10,
  parameter int LW         = 9,
  parameter int SW         = 10,
  parameter int LINES_ODD  = 263,
  parameter int LINES_EVEN = 262,
  parameter int V_BLANK    = 10,
  parameter int RD_LINE    = 5,
  parameter int RD_START   = 20,
  parameter int RD_WIDTH   = 34,
  parameter int VT_START   = 60,
  parameter int STEP_LG    = 2,
  parameter int SUB_START  = 80,
  parameter int SUB_WIDTH  = 10
) (
  input  logic [PW-1:0] px,
  input  logic [LW-1:0] ln,
  input  logic          field,
  input  logic [SW-1:0] shut_q,
  output vphase_t       vclk,
  output logic          rdg_a,
  output logic          rdg_b,
  output logic          sub_pulse
);
  localparam int VT_END = VT_START + (4 << STEP_LG);
  localparam int CW     = ((LW > SW) ? LW : SW) + 1;

  logic [1:0]    vt_step;
  logic          in_vt, in_rd, in_sub;
  logic [CW-1:0] fl_len, reach;

  always_comb begin
    vt_step = 2'((px - PW'(VT_START)) >> STEP_LG);
    in_vt   = (px >= PW'(VT_START)) && (px < PW'(VT_END));
    vclk    = in_vt ? vstep(vt_step) : VREST;

    in_rd = (ln == LW'(RD_LINE)) && (px >= PW'(RD_START)) && (px < PW'(RD_START + RD_WIDTH));
    rdg_a = in_rd && !field;
    rdg_b = in_rd && field;

    fl_len    = field ? CW'(LINES_EVEN) : CW'(LINES_ODD);
    reach     = CW'(ln) + CW'(shut_q);
    in_sub    = (px >= PW'(SUB_START)) && (px < PW'(SUB_START + SUB_WIDTH));
    sub_pulse = in_sub && (shut_q != '0) && (ln >= LW'(V_BLANK)) && (reach < fl_len);
  end
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int H_BLANK    = 100,
  parameter int H_OB_FRONT = 2,
  parameter int H_EFF      = 510,
  parameter int H_OB_REAR  = 25,
  parameter int LINES_ODD  = 263,
  parameter int LINES_EVEN = 262,
  parameter int V_BLANK    = 10,
  parameter int V_OB       = 6,
  parameter int V_ACT      = 246,
  parameter int HD_WIDTH   = 40,
  parameter int VD_WIDTH   = 3,
  parameter int RD_LINE    = 5,
  parameter int RD_START   = 20,
  parameter int RD_WIDTH   = 34,   // about 2.4 us at a 14.3 MHz pixel rate
  parameter int VT_START   = 60,
  parameter int STEP_LG    = 2,
  parameter int SUB_START  = 80,
  parameter int SUB_WIDTH  = 10,
  parameter int SHUT_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [SHUT_W-1:0] shut_lines,
  output logic              hd,
  output logic              vd,
  output logic              blank,
  output logic              field,
  output logic              h1,
  output logic              h2,
  output logic              rg,
  output logic [3:0]        vclk,
  output logic              rdg_a,
  output logic              rdg_b,
  output logic              sub_pulse,
  output logic              ob_clamp,
  output logic              samp_strobe
);
  localparam int H_TOTAL = H_BLANK + H_OB_FRONT + H_EFF + H_OB_REAR;
  localparam int PW      = $clog2(H_TOTAL);
  localparam int MAXL    = (LINES_ODD > LINES_EVEN) ? LINES_ODD : LINES_EVEN;
  localparam int LW      = $clog2(MAXL);
  localparam int EFF_LO  = H_BLANK + H_OB_FRONT;
  localparam int EFF_HI  = EFF_LO + H_EFF;
  localparam int ACT_LO  = V_BLANK + V_OB;
  localparam int ACT_HI  = ACT_LO + V_ACT;

  logic [1:0]        tick;
  logic [PW-1:0]     px;
  logic              line_end;
  logic [LW-1:0]     ln;
  logic [SHUT_W-1:0] shut_q;
  logic              in_ro, h_eff, ob_line, act_line, strobe_tick;
  vphase_t           vph;

  ccd_tg_hcnt #(.H_TOTAL(H_TOTAL), .PW(PW)) u_hcnt (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .tick(tick), .px(px), .line_end(line_end)
  );

  ccd_tg_vcnt #(.LINES_ODD(LINES_ODD), .LINES_EVEN(LINES_EVEN), .LW(LW), .SW(SHUT_W)) u_vcnt (
    .clk(clk), .rst(rst), .line_end(line_end), .shut_in(shut_lines),
    .ln(ln), .field(field), .shut_q(shut_q)
  );

  ccd_tg_vdrv #(
    .PW(PW), .LW(LW), .SW(SHUT_W), .LINES_ODD(LINES_ODD), .LINES_EVEN(LINES_EVEN),
    .V_BLANK(V_BLANK), .RD_LINE(RD_LINE), .RD_START(RD_START), .RD_WIDTH(RD_WIDTH),
    .VT_START(VT_START), .STEP_LG(STEP_LG), .SUB_START(SUB_START), .SUB_WIDTH(SUB_WIDTH)
  ) u_vdrv (
    .px(px), .ln(ln), .field(field), .shut_q(shut_q),
    .vclk(vph), .rdg_a(rdg_a), .rdg_b(rdg_b), .sub_pulse(sub_pulse)
  );

  always_comb begin
    in_ro       = px >= PW'(H_BLANK);
    h_eff       = (px >= PW'(EFF_LO)) && (px < PW'(EFF_HI));
    ob_line     = (ln >= LW'(V_BLANK)) && (ln < LW'(ACT_LO));
    act_line    = (ln >= LW'(ACT_LO)) && (ln < LW'(ACT_HI));
    strobe_tick = tick == 2'd2;

    // horizontal register held during blanking, clocked in the transfer region
    h1 = !in_ro || !tick[1];
    h2 = in_ro && tick[1];
    rg = in_ro && (tick == 2'd0);

    hd   = px < PW'(HD_WIDTH);
    vd   = ln < LW'(VD_WIDTH);
    vclk = vph;

    samp_strobe = strobe_tick && act_line && h_eff;
    ob_clamp    = strobe_tick && in_ro && (ob_line || (act_line && !h_eff));
    blank       = !(act_line && h_eff);
  end
endmodule

// File: rtl/ccd_tg_chk.sv
module ccd_tg_chk (
  input logic       clk,
  input logic       rst,
  input logic       pix_en,
  input logic       hd,
  input logic       vd,
  input logic       blank,
  input logic       field,
  input logic       h1,
  input logic       h2,
  input logic       rg,
  input logic [3:0] vclk,
  input logic       rdg_a,
  input logic       rdg_b,
  input logic       sub_pulse,
  input logic       ob_clamp,
  input logic       samp_strobe
);
  p_hold_stall_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(pix_en) && !$past(rst)) |-> ($stable(h1) && $stable(rg) && $stable(vclk) && $stable(field) && $stable(blank)));

  p_h_excl_r2: assert property (@(posedge clk) disable iff (rst) !(h1 && h2));

  p_rg_in_h1_r2: assert property (@(posedge clk) disable iff (rst) rg |-> (h1 && !h2));

  p_field_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(field) |-> (vd && hd));

  p_clamp_not_samp_r5: assert property (@(posedge clk) disable iff (rst) !(ob_clamp && samp_strobe));

  p_samp_open_r6: assert property (@(posedge clk) disable iff (rst) samp_strobe |-> !blank);

  p_vclk_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (vclk == 4'b0011) || (vclk == 4'b0110) || (vclk == 4'b1100) || (vclk == 4'b1001));

  p_vclk_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(vclk) && !$past(rst)) |-> (!h2 && !$past(h2)));

  p_rdg_excl_r8: assert property (@(posedge clk) disable iff (rst) !(rdg_a && rdg_b));

  p_rdg_field_r8: assert property (@(posedge clk) disable iff (rst)
    (rdg_a |-> !field) and (rdg_b |-> field));

  p_sub_in_blank_r9: assert property (@(posedge clk) disable iff (rst) sub_pulse |-> (blank && !h2));
endmodule

bind ccd_timing_gen ccd_tg_chk u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .hd(hd), .vd(vd), .blank(blank), .field(field),
  .h1(h1), .h2(h2), .rg(rg), .vclk(vclk), .rdg_a(rdg_a), .rdg_b(rdg_b),
  .sub_pulse(sub_pulse), .ob_clamp(ob_clamp), .samp_strobe(samp_strobe)
);

// File: tb/ccd_timing_gen_tb.sv
module ccd_timing_gen_tb;
  localparam int HB = 16, HOF = 2, HE = 6, HOR = 3;
  localparam int HT = HB + HOF + HE + HOR;
  localparam int LO = 9, LE = 8, FTOT = LO + LE;
  localparam int VB = 3, VOB = 1, VA = 3;
  localparam int HDW = 4, VDW = 2;
  localparam int RDL = 1, RDS = 2, RDW = 3;
  localparam int VTS = 8, SLG = 1, STEP = 1 << SLG;
  localparam int SUBS = 5, SUBW = 2;
  localparam int NCYC = 16000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b0;
  logic [3:0] shut_lines = 4'd0;
  logic       hd, vd, blank, field, h1, h2, rg, rdg_a, rdg_b, sub_pulse, ob_clamp, samp_strobe;
  logic [3:0] vclk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  ccd_timing_gen #(
    .H_BLANK(HB), .H_OB_FRONT(HOF), .H_EFF(HE), .H_OB_REAR(HOR),
    .LINES_ODD(LO), .LINES_EVEN(LE), .V_BLANK(VB), .V_OB(VOB), .V_ACT(VA),
    .HD_WIDTH(HDW), .VD_WIDTH(VDW), .RD_LINE(RDL), .RD_START(RDS), .RD_WIDTH(RDW),
    .VT_START(VTS), .STEP_LG(SLG), .SUB_START(SUBS), .SUB_WIDTH(SUBW), .SHUT_W(4)
  ) u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .shut_lines(shut_lines),
    .hd(hd), .vd(vd), .blank(blank), .field(field), .h1(h1), .h2(h2), .rg(rg),
    .vclk(vclk), .rdg_a(rdg_a), .rdg_b(rdg_b), .sub_pulse(sub_pulse),
    .ob_clamp(ob_clamp), .samp_strobe(samp_strobe)
  );

  always #5 clk = ~clk;

  // expected values from the enabled-tick count
  logic e_hd, e_vd, e_blank, e_field, e_h1, e_h2, e_rg, e_rda, e_rdb, e_sub, e_clamp, e_samp;
  logic [3:0] e_vclk;
  bit   e_fend;

  task automatic model(input int t, input int s);
    int sp, q, p, lf, ln, fl, k;
    bit inro, hob, obl, actl;
    sp = t % 4; q = t / 4; p = q % HT; lf = (q / HT) % FTOT;
    e_field = (lf >= LO);
    ln = e_field ? lf - LO : lf;
    fl = e_field ? LE : LO;
    k = p - HB;
    inro = (p >= HB);
    hob = inro && (k < HOF || k >= HOF + HE);
    obl = (ln >= VB) && (ln < VB + VOB);
    actl = (ln >= VB + VOB) && (ln < VB + VOB + VA);
    e_h1 = !inro || sp < 2;
    e_h2 = inro && sp >= 2;
    e_rg = inro && sp == 0;
    e_hd = p < HDW;
    e_vd = ln < VDW;
    e_clamp = (sp == 2) && ((obl && inro) || (actl && hob));
    e_samp = (sp == 2) && actl && inro && !hob;
    e_blank = !(actl && inro && !hob);
    if (p >= VTS && p < VTS + 4 * STEP) begin
      case ((p - VTS) / STEP)
        0: e_vclk = 4'b0110;
        1: e_vclk = 4'b1100;
        2: e_vclk = 4'b1001;
        default: e_vclk = 4'b0011;
      endcase
    end else e_vclk = 4'b0011;
    e_rda = (ln == RDL) && p >= RDS && p < RDS + RDW && !e_field;
    e_rdb = (ln == RDL) && p >= RDS && p < RDS + RDW && e_field;
    e_sub = (s != 0) && (ln >= VB) && (ln + s < fl) && p >= SUBS && p < SUBS + SUBW;
    e_fend = (sp == 3) && (p == HT - 1) && (lf == LO - 1 || lf == FTOT - 1);
  endtask

  task automatic chk(input string tag, input string nm, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      if (bad < 40) $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tag, nm, $time, act, exp);
    end
  endtask

  task automatic check_all(input int t, input int s, input bit shut_pending);
    model(t, s);
    chk("R3", "hd", {3'b0, hd}, {3'b0, e_hd});
    chk("R3", "vd", {3'b0, vd}, {3'b0, e_vd});
    chk("R4", "field", {3'b0, field}, {3'b0, e_field});
    chk("R2", "h1/h2/rg", {1'b0, h1, h2, rg}, {1'b0, e_h1, e_h2, e_rg});
    chk("R5", "ob_clamp", {3'b0, ob_clamp}, {3'b0, e_clamp});
    chk("R6", "samp/blank", {2'b0, samp_strobe, blank}, {2'b0, e_samp, e_blank});
    chk("R7", "vclk", vclk, e_vclk);
    chk("R8", "rdg", {2'b0, rdg_a, rdg_b}, {2'b0, e_rda, e_rdb});
    if (shut_pending) chk("R10", "sub_pulse", {3'b0, sub_pulse}, {3'b0, e_sub});
    else              chk("R9", "sub_pulse", {3'b0, sub_pulse}, {3'b0, e_sub});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int t, es;
    bit prev_en, prev_rst;
    logic [15:0] snap;
    logic [3:0] svals [6];
    svals = '{4'd0, 4'd2, 4'd5, 4'd1, 4'd12, 4'd3};
    t = 0; es = 0; prev_en = 1; prev_rst = 1; snap = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (prev_rst) begin
        // R11: state right after a synchronous reset
        chk("R11", "hd/vd/blank/field", {hd, vd, blank, field}, 4'b1110);
        chk("R11", "vclk", vclk, 4'b0011);
        chk("R11", "sub/rdg", {1'b0, sub_pulse, rdg_a, rdg_b}, 4'b0000);
      end
      check_all(t, es, shut_lines != 4'(es));
      if (!prev_en && !prev_rst)
        chk("R1", "hold", {hd, vd, blank, field, h1, h2, rg, rdg_a, rdg_b, sub_pulse, ob_clamp, samp_strobe} == snap[11:0] ? 4'd1 : 4'd0, 4'd1);
      snap = {4'b0, hd, vd, blank, field, h1, h2, rg, rdg_a, rdg_b, sub_pulse, ob_clamp, samp_strobe};
      // stimulus for the next edge
      rst = (cyc == 7000 || cyc == 7001);
      pix_en = ((cyc % 7) != 3) && !(((cyc / 600) % 5 == 2) && (cyc % 3 == 1));
      shut_lines = svals[(cyc / 1300) % 6];
      model(t, es);
      if (rst) begin
        t = 0; es = 0;
      end else if (pix_en) begin
        if (e_fend) es = int'(shut_lines);
        t++;
      end
      prev_en = pix_en;
      prev_rst = rst;
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule